// File: doc/BRIEF.md
# Split-tenure bus arbiter

This block arbitrates a pipelined host bus whose address phase and data phase are granted separately. Up to eight masters each present an active-low request. The block answers with a per-master address grant and a per-master data grant, both active low. It follows the bus control lines to see where each tenure starts and ends. These are transfer start, address-busy, address acknowledge, address retry, data-busy and transfer acknowledge, together with the transfer-type field.

An access that wins the address bus and needs data is placed in a two-entry in-order queue. It becomes eligible for the data bus once its retry window has closed without a retry. An address-only transfer never enters the queue, and a retried access is removed from it. A configuration input selects one of two arbitration modes. In fixed mode the lowest index wins. In rotating mode the search starts just after the master granted most recently. When nobody requests, the address grant is parked on the last granted master.

Top module: `split_tenure_arbiter`

## Requirements
- R1: During reset (synchronous, `rst_n` low) every address grant and every data grant is deasserted. At most one address grant and at most one data grant are low in any cycle.
- R2: With `rotate_en` low, the requesting master with the lowest index receives the address grant.
- R3: With `rotate_en` high, the search starts at the index after the most recently granted master and wraps from NM-1 to 0.
- R4: A master that holds the address grant keeps it while its request stays low, even if a higher-priority request arrives.
- R5: With no request pending, the address grant is parked on the last granted master (master 0 after reset). When another master requests, the grant moves to it in the next cycle.
- R6: No address grant is asserted in the cycle after transfer start is sampled low. None is asserted while the address tenure lasts, up to and including the cycle after address acknowledge is sampled low. None is asserted while `addr_busy_n` is low.
- R7: At most two accesses wait for or hold the data bus. While two are queued, no address grant is given.
- R8: A transfer whose `tt[3]` is 1 at transfer start is address-only and never receives a data grant.
- R9: If `artry_n` is low in the cycle after address acknowledge, that access is removed from the queue and never receives a data grant.
- R10: Data grants follow the order of the address tenures that need data. A grant is held until the final transfer acknowledge and released in the next cycle. The final acknowledge is the first for `tt[1]`=0 and the fourth for `tt[1]`=1.
- R11: No new data grant is asserted while `data_busy_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rotate_en | input | 1 | 1 selects rotating priority, 0 fixed |
| req_n | input | NM | Bus requests, active low, one per master |
| ts_n | input | 1 | Transfer start, active low |
| tt | input | TT_W | Transfer type; bit 3 address-only, bit 1 burst |
| addr_busy_n | input | 1 | Address bus busy, active low |
| aack_n | input | 1 | Address acknowledge, active low |
| artry_n | input | 1 | Address retry, active low |
| data_busy_n | input | 1 | Data bus busy, active low |
| ta_n | input | 1 | Transfer acknowledge, active low |
| agnt_n | output | NM | Address grants, active low |
| dgnt_n | output | NM | Data grants, active low |

## Verification
The bench uses the default build: eight masters, four-beat bursts, and type bits 3 and 1. With all eight masters present, the rotating search can be forced to wrap from master 7 back to master 1. Four beats let the bench check that the data grant stays held across a burst. A long data phase then lets two queued accesses block a third requester.

// File: rtl/split_tenure_arbiter.sv
module split_tenure_arbiter #(
  parameter int NM        = 8,
  parameter int TT_W      = 5,
  parameter int AONLY_BIT = 3,
  parameter int BURST_BIT = 1,
  parameter int BEATS     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rotate_en,
  input  logic [NM-1:0] req_n,
  input  logic          ts_n,
  input  logic [TT_W-1:0] tt,
  input  logic          addr_busy_n,
  input  logic          aack_n,
  input  logic          artry_n,
  input  logic          data_busy_n,
  input  logic          ta_n,
  output logic [NM-1:0] agnt_n,
  output logic [NM-1:0] dgnt_n
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [NM-1:0] req, agnt, dgnt;
  logic [IW-1:0] last, win, aown;
  logic          keep, aten, rwin, rw_need, dact;
  logic [BW-1:0] beat;
  logic [1:0]    q_cnt, n_cnt, q_ok, n_ok, q_bst, n_bst;
  logic [IW-1:0] q_own [2];
  logic [IW-1:0] n_own [2];
  logic          push, pop, drop, conf, unused_tt;

  assign req       = ~req_n;
  assign keep      = |(agnt & req);
  assign agnt_n    = ~agnt;
  assign dgnt_n    = ~dgnt;
  assign unused_tt = ^tt;

  assign push = !ts_n && !aten && !tt[AONLY_BIT];
  assign drop = rwin && rw_need && !artry_n;
  assign conf = rwin && rw_need && artry_n;
  assign pop  = dact && !ta_n && (!q_bst[0] || beat == BW'(BEATS - 1));

  always_comb begin
    int  idx;
    logic found;
    win   = last;
    found = 1'b0;
    for (int k = 0; k < NM; k++) begin
      idx = rotate_en ? (int'(last) + 1 + k) % NM : k;
      if (!found && req[idx[IW-1:0]]) begin
        win   = idx[IW-1:0];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    aown = '0;
    for (int k = 0; k < NM; k++)
      if (agnt[k]) aown = IW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      agnt    <= '0;
      last    <= '0;
      aten    <= 1'b0;
      rwin    <= 1'b0;
      rw_need <= 1'b0;
    end else begin
      rwin <= aten && !aack_n;
      if (!ts_n && !aten) begin
        aten    <= 1'b1;
        rw_need <= !tt[AONLY_BIT];
      end else if (aten && !aack_n) begin
        aten <= 1'b0;
      end
      if (!ts_n || aten || !addr_busy_n || q_cnt == 2'd2) agnt <= '0;
      else if (keep) agnt <= agnt;
      else if (|req) begin
        agnt <= NM'(1) << win;
        last <= win;
      end else agnt <= NM'(1) << last;
    end
  end

  always_comb begin
    n_own = q_own;
    n_ok  = q_ok;
    n_bst = q_bst;
    n_cnt = q_cnt;
    if (pop) begin
      n_own[0] = q_own[1];
      n_ok[0]  = q_ok[1];
      n_bst[0] = q_bst[1];
      n_ok[1]  = 1'b0;
      n_cnt    = n_cnt - 2'd1;
    end
    if (drop) n_cnt = n_cnt - 2'd1;
    if (conf && n_cnt != 2'd0) n_ok[n_cnt[1]] = 1'b1;
    if (push && n_cnt != 2'd2) begin
      n_own[n_cnt[0]] = aown;
      n_ok[n_cnt[0]]  = 1'b0;
      n_bst[n_cnt[0]] = tt[BURST_BIT];
      n_cnt           = n_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
      q_ok  <= '0;
      q_bst <= '0;
      q_own <= '{default: '0};
    end else begin
      q_cnt <= n_cnt;
      q_ok  <= n_ok;
      q_bst <= n_bst;
      q_own <= n_own;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dgnt <= '0;
      dact <= 1'b0;
      beat <= '0;
    end else if (pop) begin
      dgnt <= '0;
      dact <= 1'b0;
      beat <= '0;
    end else if (dact) begin
      if (!ta_n) beat <= beat + BW'(1);
    end else if (q_cnt != 2'd0 && q_ok[0] && data_busy_n) begin
      dgnt <= NM'(1) << q_own[0];
      dact <= 1'b1;
    end
  end

  AST_AGNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~agnt_n)); // R1
  AST_DGNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~dgnt_n)); // R1
  AST_TENURE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) aten |=> (agnt_n == '1)); // R6
  AST_QUEUE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= 2'd2); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (q_cnt == 2'd2) |=> (agnt_n == '1)); // R7
  AST_RETRY_REMOVES: assert property (@(posedge clk) disable iff (!rst_n) (drop && !pop) |=> (q_cnt == $past(q_cnt) - 2'd1)); // R9
  AST_DGNT_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n) ((dgnt_n == '1) && !(q_cnt != 2'd0 && q_ok[0])) |=> (dgnt_n == '1)); // R10
  AST_DBUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) ((dgnt_n == '1) && !data_busy_n) |=> (dgnt_n == '1)); // R11
endmodule

// File: tb/sim_split_tenure_arbiter.sv
module sim_split_tenure_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;

  logic clk = 1'b0, rst_n = 1'b0, rotate_en = 1'b0;
  logic [NM-1:0] req_n = '1;
  logic ts_n = 1'b1, addr_busy_n = 1'b1, aack_n = 1'b1, artry_n = 1'b1;
  logic data_busy_n = 1'b1, ta_n = 1'b1;
  logic [4:0] tt = '0;
  logic [NM-1:0] agnt_n, dgnt_n;

  int checks = 0, errors = 0, ta_delay = 2, dg_count = 0;
  int exp_q [$];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_tenure_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rotate_en(rotate_en), .req_n(req_n),
    .ts_n(ts_n), .tt(tt), .addr_busy_n(addr_busy_n), .aack_n(aack_n),
    .artry_n(artry_n), .data_busy_n(data_busy_n), .ta_n(ta_n),
    .agnt_n(agnt_n), .dgnt_n(dgnt_n));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int who(input logic [NM-1:0] g_n);
    int r = -1;
    for (int k = NM - 1; k >= 0; k--) if (!g_n[k]) r = k;
    return r;
  endfunction

  task automatic wait_grant(output int w);
    w = -1;
    for (int i = 0; i < 300 && w < 0; i++) begin
      @(negedge clk);
      w = who(agnt_n);
    end
  endtask

  task automatic do_access(input int m, input bit aonly, input bit burst, input bit retry);
    int w;
    @(negedge clk);
    req_n[m] = 1'b0;
    w = who(agnt_n);
    if (w != m) begin
      for (int i = 0; i < 300 && w != m; i++) begin
        @(negedge clk);
        w = who(agnt_n);
      end
    end
    chk(w == m, "R7", "address grant reached", w, m);
    ts_n = 1'b0;
    tt = {1'b0, aonly, 1'b0, burst, 1'b0};
    req_n[m] = 1'b1;
    @(negedge clk);
    ts_n = 1'b1;
    chk(agnt_n == '1, "R6", "grant off after start", who(agnt_n), -1);
    @(negedge clk);
    aack_n = 1'b0;
    chk(agnt_n == '1, "R6", "grant off in tenure", who(agnt_n), -1);
    @(negedge clk);
    aack_n = 1'b1;
    artry_n = retry ? 1'b0 : 1'b1;
    chk(agnt_n == '1, "R6", "grant off after acknowledge", who(agnt_n), -1);
    @(negedge clk);
    artry_n = 1'b1;
    if (!aonly && !retry) exp_q.push_back(m + 16 * int'(burst));
  endtask

  task automatic drain();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && dgnt_n == '1 && ta_n) break;
    end
    chk(exp_q.size() == 0, "R10", "all data tenures served", exp_q.size(), 0);
  endtask

  initial begin : monitor
    int m, item, nb;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (!$onehot0(~agnt_n)) chk(1'b0, "R1", "address grant one-hot", int'(~agnt_n), 0);
        if (!$onehot0(~dgnt_n)) chk(1'b0, "R1", "data grant one-hot", int'(~dgnt_n), 0);
        if (dgnt_n != '1) begin
          m = who(dgnt_n);
          dg_count++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected data grant", m, -1);
            nb = 1;
          end else begin
            item = exp_q.pop_front();
            chk(m == (item % 16), "R10", "data grant order", m, item % 16);
            nb = (item >= 16) ? 4 : 1;
          end
          repeat (ta_delay) @(negedge clk);
          for (int b = 0; b < nb; b++) begin
            ta_n = 1'b0;
            @(negedge clk);
            if (b < nb - 1) chk(dgnt_n != '1, "R10", "grant held in burst", b, nb);
          end
          ta_n = 1'b1;
          chk(dgnt_n == '1, "R10", "grant released after final beat", who(dgnt_n), -1);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int w, cnt0;
    repeat (3) @(negedge clk);
    chk(agnt_n == '1 && dgnt_n == '1, "R1", "grants in reset", int'(~agnt_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(who(agnt_n) == 0, "R5", "parked on master 0", who(agnt_n), 0);

    req_n[5] = 1'b0;
    req_n[2] = 1'b0;
    @(negedge clk);
    chk(who(agnt_n) == 2, "R2", "lowest index wins", who(agnt_n), 2);
    chk(who(agnt_n) == 2, "R5", "park withdrawn next cycle", who(agnt_n), 2);
    req_n[0] = 1'b0;
    @(negedge clk);
    chk(who(agnt_n) == 2, "R4", "grant kept while requesting", who(agnt_n), 2);
    do_access(2, 0, 0, 0);
    wait_grant(w);
    chk(w == 0, "R2", "master 0 ahead of 5", w, 0);
    do_access(0, 0, 0, 0);
    do_access(5, 0, 0, 0);
    drain();
    @(negedge clk);
    chk(who(agnt_n) == 5, "R5", "parked on last granted", who(agnt_n), 5);

    cnt0 = dg_count;
    do_access(4, 1, 0, 0);
    drain();
    chk(dg_count == cnt0, "R8", "no data grant for address-only", dg_count, cnt0);
    do_access(3, 0, 0, 1);
    drain();
    chk(dg_count == cnt0, "R9", "no data grant for retried access", dg_count, cnt0);
    do_access(1, 0, 0, 0);
    drain();
    chk(dg_count == cnt0 + 1, "R9", "next access still served", dg_count, cnt0 + 1);

    rotate_en = 1'b1;
    do_access(4, 0, 0, 0);
    drain();
    @(negedge clk);
    req_n[1] = 1'b0;
    req_n[6] = 1'b0;
    @(negedge clk);
    chk(who(agnt_n) == 6, "R3", "search starts after last", who(agnt_n), 6);
    req_n[5] = 1'b0;
    do_access(6, 0, 0, 0);
    wait_grant(w);
    chk(w == 1, "R3", "search wraps past master 7", w, 1);
    do_access(1, 0, 0, 0);
    do_access(5, 0, 0, 0);
    drain();
    rotate_en = 1'b0;

    do_access(2, 0, 1, 0);
    drain();

    ta_delay = 20;
    do_access(1, 0, 0, 0);
    do_access(6, 0, 0, 0);
    @(negedge clk);
    req_n[7] = 1'b0;
    repeat (4) @(negedge clk);
    chk(agnt_n == '1, "R7", "no grant with two queued", who(agnt_n), -1);
    ta_delay = 2;
    do_access(7, 0, 0, 0);
    drain();

    data_busy_n = 1'b0;
    do_access(3, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk(dgnt_n == '1, "R11", "data grant held off while busy", who(dgnt_n), -1);
    data_busy_n = 1'b1;
    drain();

    addr_busy_n = 1'b0;
    @(negedge clk);
    req_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk(agnt_n == '1, "R6", "no grant while address busy", who(agnt_n), -1);
    addr_busy_n = 1'b1;
    do_access(0, 0, 0, 0);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule